// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This controller moves 128-bit blocks through an external block cipher core and applies the chaining rules of three modes: electronic codebook, cipher block chaining and counter. It handles both encryption and decryption. The host loads a key. It then loads an initial vector or a starting counter into the context register and streams data blocks in with a valid/ready handshake. Each result comes back on a one-cycle output strobe. Only one block is in flight at a time.

The cipher core sits behind a request/done handshake. The controller raises a request with the block, the key and a direction bit. It holds all three steady until the core pulses done with its result, so a core of any latency works. The context register advances on its own after every chained block. The host can read it at any time and write it while idle. This lets a message be suspended, another message run, and the first message resume from the saved context.

Top module: `cipher_mode_ctrl`

## Requirements
- R1: After reset, busy_o, out_valid_o, err_o and eng_req_o are 0, ctx_o is 0 and in_ready_o is 1.
- R2: Mode encoding is mode_i 0 for codebook, 1 for block chaining, 2 for counter and 3 for codebook; dec_i 1 selects decryption. In codebook mode the block goes to the core unchanged with eng_dec_o equal to dec_i. The result is the core output, and ctx_o does not change.
- R3: In block-chaining encryption the core receives the block XOR ctx. The result is the core output, and that result becomes the new ctx_o.
- R4: In block-chaining decryption the core receives the block with eng_dec_o 1. The result is the core output XOR the old ctx, and the incoming ciphertext becomes the new ctx_o.
- R5: A key write marks the context as not loaded. A block-chaining block offered while the context is not loaded is accepted but not processed. err_o goes to 1, no core request is made and no result is produced. err_o stays 1 until the next context or key write.
- R6: In counter mode the core always receives ctx with eng_dec_o 0, for either direction. The result is the core output XOR the block, and ctx_o then increments by one modulo 2^128.
- R7: A context write while idle sets ctx_o to ctx_i and marks the context loaded. Restoring a saved ctx_o lets an interrupted message continue with the same results as an uninterrupted run.
- R8: Context and key writes made while busy_o is 1 are ignored.
- R9: in_ready_o is 1 only when idle and no key or context write is present. busy_o is 1 from the cycle after acceptance until out_valid_o rises. The request and its data stay steady until eng_done_i. out_valid_o is a one-cycle pulse in the cycle after eng_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Chaining mode for the offered block |
| dec_i | input | 1 | 1 = decrypt, 0 = encrypt |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 128 | Key value |
| ctx_we_i | input | 1 | Context write strobe |
| ctx_i | input | 128 | Initial vector, counter or saved context |
| ctx_o | output | 128 | Current chaining context |
| in_valid_i | input | 1 | Input block valid |
| in_data_i | input | 128 | Input block |
| in_ready_o | output | 1 | Controller can accept a block |
| out_valid_o | output | 1 | Result strobe, one cycle |
| out_data_o | output | 128 | Result block |
| busy_o | output | 1 | Block in flight |
| err_o | output | 1 | Block-chaining block offered without loaded context |
| eng_req_o | output | 1 | Request to the cipher core |
| eng_dec_o | output | 1 | Direction to the cipher core |
| eng_key_o | output | 128 | Key to the cipher core |
| eng_data_o | output | 128 | Block to the cipher core |
| eng_done_i | input | 1 | Core result valid, one cycle |
| eng_res_i | input | 128 | Core result |

## Verification
The checker watches the handshake rules on every cycle. It confirms that the ready signal never rises while busy, that the request and its data stay steady until done, and that every result strobe follows a done. It also confirms that the context holds while a block waits on the core and after a codebook block, that counter blocks always drive the forward direction, and that a raised error comes with no request. The bench scenarios alone show the mode arithmetic, because they compare results against a model built on a test permutation. The same goes for counter wrap at 2^128, the save-and-restore sequence, and the proof that writes during a busy block left both key and context untouched.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int unsigned BLK_W = 128;

  typedef enum logic [1:0] {
    MODE_ECB = 2'd0,
    MODE_CBC = 2'd1,
    MODE_CTR = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;
endpackage

// File: rtl/cmc_fsm.sv
module cmc_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic hold_i,
  input  logic reject_i,
  input  logic eng_done_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic start_o,
  output logic done_o,
  output logic busy_o
);
  typedef enum logic {ST_IDLE, ST_ENG} st_e;
  st_e st_q, st_d;

  assign in_ready_o = (st_q == ST_IDLE) && !hold_i;
  assign accept_o   = in_valid_i && in_ready_o;
  assign start_o    = accept_o && !reject_i;
  assign done_o     = (st_q == ST_ENG) && eng_done_i;
  assign busy_o     = (st_q == ST_ENG);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_o) st_d = ST_ENG;
      ST_ENG:  if (eng_done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cmc_path.sv
module cmc_path
  import cmc_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic [1:0]   mode_i,
  input  logic         dec_i,
  input  logic [W-1:0] blk_i,
  input  logic [W-1:0] ctx_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] eng_data_o,
  output logic         eng_dec_o,
  output logic [W-1:0] out_data_o,
  output logic [W-1:0] ctx_next_o,
  output logic         ctx_upd_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    eng_data_o = blk_i;
    eng_dec_o  = dec_i;
    out_data_o = res_i;
    ctx_next_o = ctx_i;
    ctx_upd_o  = 1'b0;
    unique case (mode_e'(mode_i))
      MODE_CBC: begin
        ctx_upd_o = 1'b1;
        if (dec_i) begin
          out_data_o = res_i ^ ctx_i;
          ctx_next_o = blk_i;
        end else begin
          eng_data_o = blk_i ^ ctx_i;
          ctx_next_o = res_i;
        end
      end
      MODE_CTR: begin
        eng_data_o = ctx_i;
        eng_dec_o  = 1'b0;
        out_data_o = res_i ^ blk_i;
        ctx_next_o = ctx_i + ONE;
        ctx_upd_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmc_ctx.sv
module cmc_ctx #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_ok_i,
  input  logic         upd_en_i,
  input  logic [W-1:0] upd_data_i,
  output logic [W-1:0] ctx_o,
  output logic         ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_o <= '0;
      ok_o  <= 1'b0;
    end else begin
      if (wr_en_i)       ctx_o <= wr_data_i;
      else if (upd_en_i) ctx_o <= upd_data_i;
      if (wr_en_i)       ok_o <= 1'b1;
      else if (clr_ok_i) ok_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cipher_mode_ctrl.sv
module cipher_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         dec_i,
  input  logic         key_we_i,
  input  logic [W-1:0] key_i,
  input  logic         ctx_we_i,
  input  logic [W-1:0] ctx_i,
  output logic [W-1:0] ctx_o,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         busy_o,
  output logic         err_o,
  output logic         eng_req_o,
  output logic         eng_dec_o,
  output logic [W-1:0] eng_key_o,
  output logic [W-1:0] eng_data_o,
  input  logic         eng_done_i,
  input  logic [W-1:0] eng_res_i
);
  logic         accept, start, done, reject, ctx_ok;
  logic         key_wr, ctx_wr, ctx_upd;
  logic [1:0]   mode_q;
  logic         dec_q;
  logic [W-1:0] blk_q, key_q, res_out, ctx_next;

  assign key_wr = key_we_i && !busy_o;
  assign ctx_wr = ctx_we_i && !busy_o;
  assign reject = (mode_e'(mode_i) == MODE_CBC) && !ctx_ok;

  cmc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .hold_i     (key_we_i | ctx_we_i),
    .reject_i   (reject),
    .eng_done_i (eng_done_i),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .start_o    (start),
    .done_o     (done),
    .busy_o     (busy_o)
  );

  cmc_path #(.W(W)) u_path (
    .mode_i     (mode_q),
    .dec_i      (dec_q),
    .blk_i      (blk_q),
    .ctx_i      (ctx_o),
    .res_i      (eng_res_i),
    .eng_data_o (eng_data_o),
    .eng_dec_o  (eng_dec_o),
    .out_data_o (res_out),
    .ctx_next_o (ctx_next),
    .ctx_upd_o  (ctx_upd)
  );

  cmc_ctx #(.W(W)) u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ctx_wr),
    .wr_data_i  (ctx_i),
    .clr_ok_i   (key_wr),
    .upd_en_i   (done && ctx_upd),
    .upd_data_i (ctx_next),
    .ctx_o      (ctx_o),
    .ok_o       (ctx_ok)
  );

  assign eng_req_o = busy_o;
  assign eng_key_o = key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q       <= '0;
      blk_q       <= '0;
      mode_q      <= 2'd0;
      dec_q       <= 1'b0;
      err_o       <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (key_wr) key_q <= key_i;
      if (start) begin
        blk_q  <= in_data_i;
        mode_q <= mode_i;
        dec_q  <= dec_i;
      end
      if (accept && reject)    err_o <= 1'b1;
      else if (key_wr || ctx_wr) err_o <= 1'b0;
      out_valid_o <= done;
      if (done) out_data_o <= res_out;
    end
  end
endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy_o,
  input logic         in_ready_o,
  input logic         eng_req_o,
  input logic         eng_dec_o,
  input logic [W-1:0] eng_data_o,
  input logic         eng_done_i,
  input logic         out_valid_o,
  input logic         err_o,
  input logic [W-1:0] ctx_o,
  input logic [1:0]   mode_q
);
  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !busy_o);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_data_o));
  // R9
  out_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(eng_done_i) && !busy_o);
  // R8
  ctx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !eng_done_i |=> $stable(ctx_o));
  // R6
  ctr_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && mode_q == 2'd2 |-> !eng_dec_o);
  // R2
  ecb_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && eng_done_i && (mode_q == 2'd0 || mode_q == 2'd3) |=> $stable(ctx_o));
  // R5
  err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !eng_req_o && !out_valid_o);
endmodule

bind cipher_mode_ctrl cmc_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .in_ready_o (in_ready_o),
  .eng_req_o  (eng_req_o),
  .eng_dec_o  (eng_dec_o),
  .eng_data_o (eng_data_o),
  .eng_done_i (eng_done_i),
  .out_valid_o(out_valid_o),
  .err_o      (err_o),
  .ctx_o      (ctx_o),
  .mode_q     (mode_q)
);

// File: tb/cipher_mode_ctrl_bench.sv
module cipher_mode_ctrl_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic         dec_i = 1'b0;
  logic         key_we_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         ctx_we_i = 1'b0;
  logic [127:0] ctx_i = '0;
  logic [127:0] ctx_o;
  logic         in_valid_i = 1'b0;
  logic [127:0] in_data_i = '0;
  logic         in_ready_o, out_valid_o, busy_o, err_o;
  logic [127:0] out_data_o;
  logic         eng_req_o, eng_dec_o;
  logic [127:0] eng_key_o, eng_data_o;
  logic         eng_done_i;
  logic [127:0] eng_res_i;

  int n_chk = 0, n_fail = 0, lat = 9, eng_cnt = 0, done_cnt = 0;

  always #10 clk_i = ~clk_i;

  cipher_mode_ctrl u_cipher_mode_ctrl (.*);

  function automatic logic [127:0] f_enc(input logic [127:0] k, input logic [127:0] x);
    logic [127:0] t;
    t = x ^ k;
    return {t[114:0], t[127:115]} + k;
  endfunction

  function automatic logic [127:0] f_dec(input logic [127:0] k, input logic [127:0] y);
    logic [127:0] t;
    t = y - k;
    return {t[12:0], t[127:13]} ^ k;
  endfunction

  // engine model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_done_i <= 1'b0;
      eng_res_i  <= '0;
      eng_cnt    <= 0;
    end else if (eng_done_i) begin
      eng_done_i <= 1'b0;
      eng_cnt    <= 0;
    end else if (eng_req_o) begin
      if (eng_cnt >= lat) begin
        eng_done_i <= 1'b1;
        eng_res_i  <= eng_dec_o ? f_dec(eng_key_o, eng_data_o) : f_enc(eng_key_o, eng_data_o);
        done_cnt   <= done_cnt + 1;
      end else eng_cnt <= eng_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctx(input logic [127:0] v);
    @(negedge clk_i); ctx_we_i = 1'b1; ctx_i = v;
    @(negedge clk_i); ctx_we_i = 1'b0;
  endtask

  task automatic wr_key(input logic [127:0] v);
    @(negedge clk_i); key_we_i = 1'b1; key_i = v;
    @(negedge clk_i); key_we_i = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] m, input bit d, input logic [127:0] din,
                      output logic [127:0] dout);
    int n;
    @(negedge clk_i);
    mode_i = m; dec_i = d; in_data_i = din; in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(busy_o && !in_ready_o, "R9 busy after accept", {126'd0, busy_o, in_ready_o}, 128'd2);
    n = 1;
    while (!out_valid_o && n < 1000) begin
      @(negedge clk_i); n++;
    end
    chk(out_valid_o && n > lat, "R9 result strobe after core latency", n, lat + 1);
    dout = out_data_o;
    @(negedge clk_i);
    chk(!out_valid_o && !busy_o, "R9 strobe one cycle", {126'd0, out_valid_o, busy_o}, 128'd0);
  endtask

  localparam logic [127:0] KEY_A = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  localparam logic [127:0] IV_A  = 128'h00112233445566778899aabbccddeeff;

  function automatic logic [127:0] pat(input int i);
    return {4{32'h9e3779b9 * (i + 1)}} ^ {32'(i), 96'h5a5a_1234_abcd_0001_7777_3c3c};
  endfunction

  task automatic t_reset;
    chk(!busy_o && !out_valid_o && !err_o && !eng_req_o && in_ready_o, "R1 reset flags",
        {123'd0, busy_o, out_valid_o, err_o, eng_req_o, in_ready_o}, 128'd1);
    chk(ctx_o == '0, "R1 reset ctx", ctx_o, '0);
  endtask

  task automatic t_ecb;
    logic [127:0] r, c;
    wr_key(KEY_A);
    wr_ctx(IV_A);
    for (int i = 0; i < 3; i++) begin
      xfer(2'd0, 1'b0, pat(i), c);
      chk(c == f_enc(KEY_A, pat(i)), "R2 codebook encrypt", c, f_enc(KEY_A, pat(i)));
      xfer(2'd3, 1'b1, c, r);
      chk(r == pat(i), "R2 codebook decrypt (mode 3)", r, pat(i));
    end
    chk(ctx_o == IV_A, "R2 ctx untouched", ctx_o, IV_A);
  endtask

  logic [127:0] cbc_ct [4];

  task automatic t_cbc_enc;
    logic [127:0] prev, c, e;
    wr_ctx(IV_A);
    prev = IV_A;
    for (int i = 0; i < 4; i++) begin
      xfer(2'd1, 1'b0, pat(i), c);
      e = f_enc(KEY_A, pat(i) ^ prev);
      chk(c == e, "R3 chained encrypt", c, e);
      chk(ctx_o == e, "R3 ctx follows ciphertext", ctx_o, e);
      cbc_ct[i] = c;
      prev = e;
    end
  endtask

  task automatic t_cbc_dec;
    logic [127:0] p;
    wr_ctx(IV_A);
    for (int i = 0; i < 4; i++) begin
      xfer(2'd1, 1'b1, cbc_ct[i], p);
      chk(p == pat(i), "R4 chained decrypt", p, pat(i));
      chk(ctx_o == cbc_ct[i], "R4 ctx takes ciphertext", ctx_o, cbc_ct[i]);
    end
  endtask

  task automatic t_cbc_noiv;
    int d0;
    wr_key(KEY_A);
    d0 = done_cnt;
    @(negedge clk_i);
    mode_i = 2'd1; dec_i = 1'b0; in_data_i = pat(7); in_valid_i = 1'b1;
    chk(in_ready_o, "R5 block accepted", {127'd0, in_ready_o}, 128'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(err_o && !busy_o, "R5 error raised, nothing started", {126'd0, err_o, busy_o}, 128'd2);
    for (int i = 0; i < lat + 4; i++) begin
      @(negedge clk_i);
      if (out_valid_o || eng_req_o) chk(0, "R5 no output or request", {126'd0, out_valid_o, eng_req_o}, 0);
    end
    chk(done_cnt == d0 && err_o, "R5 no core work, error held", done_cnt, d0);
    wr_ctx(IV_A);
    chk(!err_o, "R5 error cleared by ctx write", {127'd0, err_o}, 0);
  endtask

  task automatic t_ctr;
    logic [127:0] ctr, o, e;
    logic [127:0] ct [3];
    ctr = {{127{1'b1}}, 1'b0};
    wr_ctx(ctr);
    for (int i = 0; i < 3; i++) begin
      xfer(2'd2, 1'b0, pat(i + 10), o);
      e = f_enc(KEY_A, ctr) ^ pat(i + 10);
      chk(o == e, "R6 counter encrypt", o, e);
      ct[i] = o;
      ctr = ctr + 128'd1;
      chk(ctx_o == ctr, "R6 counter step and wrap", ctx_o, ctr);
    end
    chk(ctx_o == 128'd1, "R6 counter wrapped past 2^128", ctx_o, 128'd1);
    wr_ctx({{127{1'b1}}, 1'b0});
    for (int i = 0; i < 3; i++) begin
      xfer(2'd2, 1'b1, ct[i], o);
      chk(o == pat(i + 10), "R6 counter decrypt", o, pat(i + 10));
    end
  endtask

  task automatic t_switch;
    logic [127:0] saved, c, prev, e;
    wr_ctx(IV_A);
    chk(ctx_o == IV_A, "R7 ctx readable after write", ctx_o, IV_A);
    xfer(2'd1, 1'b0, pat(0), c);
    xfer(2'd1, 1'b0, pat(1), c);
    saved = ctx_o;
    wr_ctx(128'hdead_beef);
    xfer(2'd1, 1'b0, pat(20), c);
    wr_ctx(saved);
    prev = saved;
    for (int i = 2; i < 4; i++) begin
      xfer(2'd1, 1'b0, pat(i), c);
      e = f_enc(KEY_A, pat(i) ^ prev);
      chk(c == cbc_ct[i] && c == e, "R7 resumed message matches", c, cbc_ct[i]);
      prev = c;
    end
  endtask

  task automatic t_busy_write;
    logic [127:0] c, e;
    lat = 20;
    wr_ctx(IV_A);
    fork
      xfer(2'd1, 1'b0, pat(0), c);
      begin
        repeat (4) @(negedge clk_i);
        ctx_we_i = 1'b1; ctx_i = 128'h1234;
        key_we_i = 1'b1; key_i = 128'h5678;
        @(negedge clk_i);
        ctx_we_i = 1'b0; key_we_i = 1'b0;
      end
    join
    chk(c == cbc_ct[0], "R8 result unaffected by busy writes", c, cbc_ct[0]);
    chk(ctx_o == cbc_ct[0], "R8 ctx write while busy ignored", ctx_o, cbc_ct[0]);
    lat = 3;
    xfer(2'd0, 1'b0, pat(5), c);
    e = f_enc(KEY_A, pat(5));
    chk(c == e, "R8 key write while busy ignored", c, e);
  endtask

  task automatic t_ready_hold;
    @(negedge clk_i);
    ctx_we_i = 1'b1; ctx_i = IV_A; in_valid_i = 1'b1; mode_i = 2'd0;
    #1;
    chk(!in_ready_o, "R9 ready low during write", {127'd0, in_ready_o}, 0);
    @(negedge clk_i);
    ctx_we_i = 1'b0; in_valid_i = 1'b0;
    chk(!busy_o, "R9 nothing accepted during write", {127'd0, busy_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ecb();
    t_cbc_enc();
    t_cbc_dec();
    t_cbc_noiv();
    t_ctr();
    t_switch();
    t_busy_write();
    t_ready_hold();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule